// File: doc/BRIEF.md
# SPI Packet Handshake Controller

This block is the device side of a full-duplex SPI slave that exchanges fixed 32-bit packets with a host controller. Besides the usual select, clock and data pins, it drives an active-low handshake line (`ready_n`). The device pulls this line low when it wants the host to start a transfer. It pulses the line when it has finished handling a packet. Every packet the host clocks in is answered, bit for bit, by an identification word. The only exception is a waiting status packet, which is sent in its place once output is allowed.

After reset the block waits a programmable number of clock cycles and then asks the host to read its identification word. The host then sends configuration packets (general, receiver and address settings), which the block stores. A control packet turns decoding on or off. A checksum packet permits unsolicited output. When an external sync-detected strobe arrives while decoding is on, the block queues a status packet reporting synchronous mode. Once output is allowed, it requests a transfer to deliver that packet. A packet cut short by the select line is discarded without any handshake.

The control state machine has six states:
- `ST_BOOT` waits out the power-up delay.
- `ST_REQ` holds `ready_n` low to request a transfer.
- `ST_XFER` covers a packet in flight.
- `ST_ACK_HI` and `ST_ACK_LO` form the end-of-packet pulse, each lasting `ACK_LEN` cycles.
- `ST_IDLE` waits for the next transfer.

The transitions are:
- BOOT→REQ when the delay expires.
- REQ→XFER and IDLE→XFER on select falling.
- IDLE→REQ when a status packet is pending and output is enabled.
- XFER→ACK_HI on a complete packet.
- XFER→IDLE on a cut-short packet.
- ACK_HI→ACK_LO→IDLE, each after `ACK_LEN` cycles.

Top module: `pkt_link_ctrl`

## Requirements
- R1: After reset is released, `ready_n` stays high for `STARTUP_CYCLES` clock cycles (within a few cycles of synchroniser latency). It then goes low and stays low until the host pulls `ss_n` low.
- R2: On every transfer with no status packet selected, `miso` returns the identification word `{8'h01, DEV_ID}`. The word is sent MSB first, and each bit is valid before the SCLK rising edge (SPI mode 0).
- R3: Incoming packets are 32 bits, sampled on SCLK rising edges, MSB first. Bits 31:24 are the type code: 0x10 general, 0x11 receiver, 0x12 address, 0x20 control, 0x30 checksum. Any other code is ignored.
- R4: After a complete packet (select rises after exactly 32 SCLK rising edges), `ready_n` stays high for `ACK_LEN` cycles, then goes low for `ACK_LEN` cycles, then returns high.
- R5: Configuration packets of type 0x10, 0x11 and 0x12 store their low 24 bits on `cfg_general`, `cfg_receiver` and `cfg_address` respectively.
- R6: A control packet (type 0x20) sets `decode_en` to packet bit 0. `decode_en` is 0 after reset.
- R7: A checksum packet (type 0x30) sets `out_en` to 1. `out_en` is 0 after reset.
- R8: A `sync_det` pulse while `decode_en` is 0 is ignored: no transfer request follows, and the next transfer returns the identification word.
- R9: A `sync_det` pulse while `decode_en` is 1 queues one status packet `32'h4000_0001`. When `out_en` is 1, the block requests a transfer by driving `ready_n` low from idle and sends the status word in the next transfer. Once all 32 bits have been sent, the queue is cleared and later transfers return the identification word.
- R10: While `out_en` is 0, a queued status packet produces no transfer request, and transfers return the identification word.
- R11: If `ss_n` rises before 32 bits have arrived, the partial packet is discarded: no register changes, no end-of-packet pulse, and a queued status packet stays queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from host |
| ss_n | input | 1 | Active-low slave select from host |
| mosi | input | 1 | Host-to-device serial data |
| sync_det | input | 1 | One-cycle strobe: channel sync found |
| miso | output | 1 | Device-to-host serial data |
| ready_n | output | 1 | Active-low handshake/request line |
| decode_en | output | 1 | Decoding enabled by control packet |
| out_en | output | 1 | Unsolicited output permitted |
| cfg_general | output | 24 | Stored general settings |
| cfg_receiver | output | 24 | Stored receiver settings |
| cfg_address | output | 24 | Stored address settings |

## Verification
The checker watches, on every clock cycle:
- that `ready_n` stays high before the start-up delay has ended;
- that `decode_en` and `out_en` only change right after a complete packet;
- that a cut-short packet never leads into the acknowledge pulse;
- that a complete packet always does;
- that the status queue empties only on a complete packet;
- that a sync strobe with decoding off never fills the queue.

Only the bench scenarios can show the rest:
- the serial content returned on `miso`, including the swap to the status word and back;
- the exact length of the handshake pulse;
- the start-up timing;
- the way the checksum packet releases a queued status request.

// File: rtl/pkt_link_pkg.sv
package pkt_link_pkg;

    localparam int PKT_W  = 32;
    localparam int TYPE_W = 8;
    localparam int BODY_W = PKT_W - TYPE_W;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_REQ,
        ST_XFER,
        ST_ACK_HI,
        ST_ACK_LO,
        ST_IDLE
    } link_state_t;

    localparam logic [TYPE_W-1:0] TY_IDENT   = 8'h01;
    localparam logic [TYPE_W-1:0] TY_CFG_GEN = 8'h10;
    localparam logic [TYPE_W-1:0] TY_CFG_RCV = 8'h11;
    localparam logic [TYPE_W-1:0] TY_CFG_ADR = 8'h12;
    localparam logic [TYPE_W-1:0] TY_CTRL    = 8'h20;
    localparam logic [TYPE_W-1:0] TY_CSUM    = 8'h30;
    localparam logic [TYPE_W-1:0] TY_STAT    = 8'h40;

endpackage

// File: rtl/pkt_startup_timer.sv
module pkt_startup_timer #(
    parameter int CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/pkt_shift_port.sv
module pkt_shift_port #(
    parameter int PKT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             ss_n,
    input  logic             mosi,
    input  logic [PKT_W-1:0] tx_word,
    output logic             miso,
    output logic             start,
    output logic             done,
    output logic             abort,
    output logic [PKT_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(PKT_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(PKT_W);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(PKT_W + 1);

    logic sclk_q, sclk_qq, ss_q, ss_qq, mosi_q;
    logic [PKT_W-1:0] tx_sr, rx_sr;
    logic [CNT_W-1:0] bit_cnt;
    logic sck_rise, sck_fall, ss_fall, ss_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            ss_q    <= 1'b1;
            ss_qq   <= 1'b1;
            mosi_q  <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            ss_q    <= ss_n;
            ss_qq   <= ss_q;
            mosi_q  <= mosi;
        end
    end

    assign ss_fall  = ss_qq & ~ss_q;
    assign ss_rise  = ~ss_qq & ss_q;
    assign sck_rise = ~ss_q & sclk_q & ~sclk_qq;
    assign sck_fall = ~ss_q & ~sclk_q & sclk_qq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else if (ss_fall) begin
            tx_sr   <= tx_word;
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else if (sck_rise) begin
            rx_sr <= {rx_sr[PKT_W-2:0], mosi_q};
            if (bit_cnt != SAT) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end else if (sck_fall) begin
            tx_sr <= {tx_sr[PKT_W-2:0], 1'b0};
        end
    end

    assign miso    = tx_sr[PKT_W-1];
    assign start   = ss_fall;
    assign done    = ss_rise && (bit_cnt == FULL);
    assign abort   = ss_rise && (bit_cnt != FULL);
    assign rx_word = rx_sr;
endmodule

// File: rtl/pkt_cmd_regs.sv
module pkt_cmd_regs
    import pkt_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_done,
    input  logic [PKT_W-1:0]  rx_word,
    output logic              decode_en,
    output logic              out_en,
    output logic [BODY_W-1:0] cfg_general,
    output logic [BODY_W-1:0] cfg_receiver,
    output logic [BODY_W-1:0] cfg_address
);
    logic [TYPE_W-1:0] ty;
    logic [BODY_W-1:0] body;

    assign ty   = rx_word[PKT_W-1 -: TYPE_W];
    assign body = rx_word[BODY_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            decode_en    <= 1'b0;
            out_en       <= 1'b0;
            cfg_general  <= '0;
            cfg_receiver <= '0;
            cfg_address  <= '0;
        end else if (pkt_done) begin
            unique case (ty)
                TY_CFG_GEN: cfg_general  <= body;
                TY_CFG_RCV: cfg_receiver <= body;
                TY_CFG_ADR: cfg_address  <= body;
                TY_CTRL:    decode_en    <= body[0];
                TY_CSUM:    out_en       <= 1'b1;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/pkt_link_ctrl.sv
module pkt_link_ctrl
    import pkt_link_pkg::*;
#(
    parameter int              STARTUP_CYCLES = 32768,
    parameter int              ACK_LEN        = 4,
    parameter logic [23:0]     DEV_ID         = 24'h5A0C31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              ss_n,
    input  logic              mosi,
    input  logic              sync_det,
    output logic              miso,
    output logic              ready_n,
    output logic              decode_en,
    output logic              out_en,
    output logic [BODY_W-1:0] cfg_general,
    output logic [BODY_W-1:0] cfg_receiver,
    output logic [BODY_W-1:0] cfg_address
);
    localparam int ACK_W = $clog2(ACK_LEN + 1);
    localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACK_LEN - 1);
    localparam logic [PKT_W-1:0] IDENT_WORD  = {TY_IDENT, DEV_ID};
    localparam logic [PKT_W-1:0] STATUS_WORD = {TY_STAT, {(BODY_W-1){1'b0}}, 1'b1};

    link_state_t      state, state_nx;
    logic [ACK_W-1:0] ack_cnt;
    logic             boot_done, pkt_start, pkt_done, pkt_abort;
    logic             status_pend, tx_is_stat, sel_stat;
    logic [PKT_W-1:0] tx_word, rx_word;

    pkt_startup_timer #(.CYCLES(STARTUP_CYCLES)) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .done (boot_done)
    );

    assign sel_stat = status_pend && out_en;
    assign tx_word  = sel_stat ? STATUS_WORD : IDENT_WORD;

    pkt_shift_port #(.PKT_W(PKT_W)) port_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (sclk),
        .ss_n   (ss_n),
        .mosi   (mosi),
        .tx_word(tx_word),
        .miso   (miso),
        .start  (pkt_start),
        .done   (pkt_done),
        .abort  (pkt_abort),
        .rx_word(rx_word)
    );

    pkt_cmd_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_done    (pkt_done),
        .rx_word     (rx_word),
        .decode_en   (decode_en),
        .out_en      (out_en),
        .cfg_general (cfg_general),
        .cfg_receiver(cfg_receiver),
        .cfg_address (cfg_address)
    );

    // Status queue: a new sync strobe wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_pend <= 1'b0;
            tx_is_stat  <= 1'b0;
        end else begin
            if (pkt_start) begin
                tx_is_stat <= sel_stat;
            end
            if (sync_det && decode_en) begin
                status_pend <= 1'b1;
            end else if (pkt_done && tx_is_stat) begin
                status_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT:   if (boot_done) state_nx = ST_REQ;
            ST_REQ:    if (pkt_start) state_nx = ST_XFER;
            ST_XFER: begin
                if (pkt_done)       state_nx = ST_ACK_HI;
                else if (pkt_abort) state_nx = ST_IDLE;
            end
            ST_ACK_HI: if (ack_cnt == ACK_LAST) state_nx = ST_ACK_LO;
            ST_ACK_LO: if (ack_cnt == ACK_LAST) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (pkt_start)     state_nx = ST_XFER;
                else if (sel_stat) state_nx = ST_REQ;
            end
            default:   state_nx = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_BOOT;
            ack_cnt <= '0;
        end else begin
            state   <= state_nx;
            ack_cnt <= (state_nx != state) ? '0 : ack_cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_REQ, ST_ACK_LO: ready_n = 1'b0;
            default:           ready_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/pkt_link_ctrl_chk.sv
module pkt_link_ctrl_chk
    import pkt_link_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ready_n,
    input logic        boot_done,
    input logic        pkt_done,
    input logic        pkt_abort,
    input link_state_t state,
    input logic        decode_en,
    input logic        out_en,
    input logic        status_pend,
    input logic        sync_det
);
    logic boot_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         boot_seen <= 1'b0;
        else if (boot_done) boot_seen <= 1'b1;
    end

    AST_QUIET_BEFORE_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_seen && !boot_done) |-> ready_n);  // R1

    AST_DECODE_FROM_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(decode_en) |-> $past(pkt_done));  // R6

    AST_OUTPUT_FROM_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> $past(pkt_done));  // R7

    AST_FULL_PACKET_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && state == ST_XFER) |=> (state == ST_ACK_HI));  // R4

    AST_PARTIAL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_abort |=> (state != ST_ACK_HI && ready_n));  // R11

    AST_QUEUE_CLEARS_ON_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_pend) |-> $past(pkt_done));  // R9

    AST_SYNC_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_det && !decode_en && !status_pend) |=> !status_pend);  // R8
endmodule

bind pkt_link_ctrl pkt_link_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_n    (ready_n),
    .boot_done  (boot_done),
    .pkt_done   (pkt_done),
    .pkt_abort  (pkt_abort),
    .state      (state),
    .decode_en  (decode_en),
    .out_en     (out_en),
    .status_pend(status_pend),
    .sync_det   (sync_det)
);

// File: tb/pkt_link_ctrl_tb_top.sv
module pkt_link_ctrl_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          BOOT_CYC   = 50;
    localparam int          ACK_N      = 4;
    localparam logic [23:0] ID_VAL     = 24'hA5C3E1;
    localparam logic [31:0] ID_WORD    = {8'h01, ID_VAL};
    localparam logic [31:0] STAT_WORD  = 32'h4000_0001;

    // {packet sent, expected decode_en, expected out_en}
    localparam int NVEC = 5;
    localparam logic [33:0] VEC [NVEC] = '{
        {32'h1012_3456, 1'b0, 1'b0},
        {32'h11AB_CDEF, 1'b0, 1'b0},
        {32'h1200_F00F, 1'b0, 1'b0},
        {32'h2000_0000, 1'b0, 1'b0},
        {32'h2000_0001, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0, sync_det = 1'b0;
    logic miso, ready_n, decode_en, out_en;
    logic [23:0] cfg_general, cfg_receiver, cfg_address;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_link_ctrl #(.STARTUP_CYCLES(BOOT_CYC), .ACK_LEN(ACK_N), .DEV_ID(ID_VAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .sync_det(sync_det), .miso(miso), .ready_n(ready_n), .decode_en(decode_en),
        .out_en(out_en), .cfg_general(cfg_general), .cfg_receiver(cfg_receiver),
        .cfg_address(cfg_address)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] w, input int nbits, output logic [31:0] r);
        r = '0;
        @(negedge clk);
        ss_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = w[31-i];
            waitc(4);
            r = {r[30:0], miso};
            sclk = 1'b1;
            waitc(4);
            sclk = 1'b0;
        end
        waitc(4);
        ss_n = 1'b1;
    endtask

    // counts low cycles of ready_n until it returns high after being low
    task automatic ack_lows(output int n);
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!ready_n) n++;
            else if (n > 0) break;
        end
    endtask

    task automatic stays_high(input int cyc, output bit ok);
        ok = 1;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (!ready_n) ok = 0;
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] r;
        int n;
        bit ok;

        waitc(5);
        rst_n = 1'b1;
        waitc(1);
        check(ready_n == 1'b1, "R1 reset ready_n", {31'b0, ready_n}, 32'h1);
        check(decode_en == 1'b0, "R6 reset decode_en", {31'b0, decode_en}, 32'h0);
        check(out_en == 1'b0, "R7 reset out_en", {31'b0, out_en}, 32'h0);

        // R1: start-up delay then identification request
        n = 1;
        while (ready_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n >= BOOT_CYC - 1 && n <= BOOT_CYC + 3, "R1 boot delay", n, BOOT_CYC);
        waitc(10);
        check(ready_n == 1'b0, "R1 request held", {31'b0, ready_n}, 32'h0);

        // table walk: configuration and control packets
        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][33:2], 32, r);
            check(r == ID_WORD, "R2 ident reply", r, ID_WORD);
            ack_lows(n);
            check(n == ACK_N, "R4 ack pulse", n, ACK_N);
            check(decode_en == VEC[v][1], "R6 decode_en", {31'b0, decode_en}, {31'b0, VEC[v][1]});
            check(out_en == VEC[v][0], "R7 out_en", {31'b0, out_en}, {31'b0, VEC[v][0]});
            waitc(3);
        end
        check(cfg_general == 24'h123456, "R5 R3 general", {8'b0, cfg_general}, 32'h123456);
        check(cfg_receiver == 24'hABCDEF, "R5 R3 receiver", {8'b0, cfg_receiver}, 32'hABCDEF);
        check(cfg_address == 24'h00F00F, "R5 R3 address", {8'b0, cfg_address}, 32'h00F00F);

        // R10: status queued but output not yet permitted
        @(negedge clk); sync_det = 1'b1;
        @(negedge clk); sync_det = 1'b0;
        stays_high(20, ok);
        check(ok, "R10 no request", {31'b0, ok}, 32'h1);
        xfer(32'h0000_0000, 32, r);
        check(r == ID_WORD, "R10 ident reply", r, ID_WORD);
        ack_lows(n);

        // R7 then R9: checksum releases queued status
        xfer(32'h3000_0000, 32, r);
        check(r == ID_WORD, "R7 ident reply", r, ID_WORD);
        ack_lows(n);
        check(n == ACK_N, "R4 ack pulse checksum", n, ACK_N);
        check(out_en == 1'b1, "R7 out_en set", {31'b0, out_en}, 32'h1);
        waitc(4);
        check(ready_n == 1'b0, "R9 status request", {31'b0, ready_n}, 32'h0);
        xfer(32'h0000_0000, 32, r);
        check(r == STAT_WORD, "R9 status reply", r, STAT_WORD);
        ack_lows(n);
        check(n == ACK_N, "R4 ack pulse status", n, ACK_N);
        stays_high(10, ok);
        check(ok, "R9 queue cleared", {31'b0, ok}, 32'h1);
        xfer(32'h0000_0000, 32, r);
        check(r == ID_WORD, "R9 ident after status", r, ID_WORD);
        ack_lows(n);

        // R11: cut-short packet
        xfer(32'h1077_7777, 16, r);
        ack_lows(n);
        check(n == 0, "R11 no ack pulse", n, 0);
        check(cfg_general == 24'h123456, "R11 cfg kept", {8'b0, cfg_general}, 32'h123456);
        xfer(32'h0000_0000, 32, r);
        check(r == ID_WORD, "R11 recovery reply", r, ID_WORD);
        ack_lows(n);
        check(n == ACK_N, "R11 recovery ack", n, ACK_N);

        // R8: sync ignored with decoding off
        xfer(32'h2000_0000, 32, r);
        ack_lows(n);
        check(decode_en == 1'b0, "R6 decode off", {31'b0, decode_en}, 32'h0);
        @(negedge clk); sync_det = 1'b1;
        @(negedge clk); sync_det = 1'b0;
        stays_high(20, ok);
        check(ok, "R8 no request", {31'b0, ok}, 32'h1);
        xfer(32'h0000_0000, 32, r);
        check(r == ID_WORD, "R8 ident reply", r, ID_WORD);
        ack_lows(n);

        summary();
    end
endmodule